// File: doc/BRIEF.md
# DMA Channel Register and Termination Engine

This block keeps the programmable state of a four-channel direct memory access controller: a 16-bit address and a 16-bit count word for each channel, an 8-bit mode register and a 5-bit status register. A host processor loads and reads these registers through a small register port. An external sequencer reports each finished bus cycle with a one-cycle `xfer_done` pulse and the channel number. The engine then advances that channel's address and count, detects terminal count, and can reload channel 2 from channel 3.

In the same cycle as the pulse, the engine decodes the channel's transfer type into memory and I/O strobe enables. It also raises a flag when extended write timing applies. Arbitration between channels and the bus timing are handled by neighbouring blocks. The rotating-priority bit is stored here only so that the arbiter can use it.

The count word holds the transfer count in bits 13:0 and the transfer type in bits 15:14. The count is programmed as the number of transfers minus one.

Top module: `dma_chreg_engine`

## Requirements
- R1: After reset every address register, count word, the mode register and the status register read as zero, and no strobe, terminal-count or ext_write output is active.
- R2: A CPU write to select 2n loads channel n's address and a write to 2n+1 loads its count word. A write to select 8 loads the mode register (bit n enables channel n, bit 4 rotating priority, bit 5 extended write, bit 6 stop at terminal count, bit 7 autoload). A combinational read at select 2n, 2n+1 or 9 returns the address, count word or mode register.
- R3: A transfer on an enabled channel of a legal type increments its address by one (wrapping at 16 bits) and decrements its 14-bit count, keeping the type bits. Both take effect on the next clock edge.
- R4: In the pulse cycle, type 10 (read) asserts mem_rd_en and io_wr_en. Type 01 (write) asserts io_rd_en and mem_wr_en. Type 00 (verify) asserts no strobe but still advances the address and count.
- R5: A transfer pulse for a disabled channel, or for a channel whose type is 11, asserts no strobe and no terminal count and leaves every register unchanged.
- R6: A transfer taken while the count field is zero pulses that channel's ch_tc bit in the same cycle, sets status bit n, and wraps the count field to 3FFF.
- R7: When mode bit 6 is set, the enable bit of the channel that reaches terminal count clears. When bit 6 is clear, the channel stays enabled.
- R8: When mode bit 7 is set and channel 2 reaches terminal count, channel 2's address and count word are loaded from channel 3 on the next edge. Status bit 4 is set, and channel 2 stays enabled even if bit 6 is set.
- R9: A read at select 8 returns the status in bits 4:0. When cpu_rd is high with select 8, the status clears on that edge, except for bits that a transfer sets in the same cycle.
- R10: ext_write is high in a pulse cycle only when mode bit 5 is set and the transfer asserts a write strobe (read or write type). It is low for verify.
- R11: When a CPU write to a channel's address or count word coincides with a transfer on that channel, the written register takes the CPU value. The other register still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (clears status at select 8) |
| cpu_sel | input | 4 | Register select |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Combinational read data for cpu_sel |
| xfer_done | input | 1 | One-cycle pulse: a transfer finished |
| xfer_ch | input | 2 | Channel of the finished transfer |
| ch_addr | output | 64 | Current address of each channel, channel n at bits 16n+15:16n |
| ch_tc | output | 4 | Terminal-count pulse for each channel |
| mem_rd_en | output | 1 | Memory read strobe enable |
| mem_wr_en | output | 1 | Memory write strobe enable |
| io_rd_en | output | 1 | I/O read strobe enable |
| io_wr_en | output | 1 | I/O write strobe enable |
| ext_write | output | 1 | Extended write timing applies to this transfer |

## Verification
A wrong count appears at the ports as a ch_tc pulse in the wrong transfer or a missing one. A wrong address shows on ch_addr on the edge after the pulse. A lost status event stays hidden until the next status read, so the bench reads status right after each terminal count and also while a new event is arriving. A missed autoload or a wrong enable clear shows on the next edge in ch_addr and in the mode readback.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;
   typedef enum logic [1:0] {
      XT_VERIFY = 2'b00,
      XT_WRITE  = 2'b01,
      XT_READ   = 2'b10,
      XT_BAD    = 2'b11
   } xfer_type_e;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
   } strobe_t;
endpackage

// File: rtl/dma_ch_slot.sv
module dma_ch_slot #(
   parameter int AW = 16,
   parameter int CW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_addr,
   input  logic          ld_word,
   input  logic [AW-1:0] wdata,
   input  logic          adv,
   input  logic          rld,
   input  logic [AW-1:0] rld_addr,
   input  logic [AW-1:0] rld_word,
   output logic [AW-1:0] addr_q,
   output logic [AW-1:0] word_q
);
   localparam int TW = AW - CW;

   if (TW != 2) begin : g_bad_w
      $error("dma_ch_slot: AW must equal CW + 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         word_q <= '0;
      end else begin
         if (ld_addr)  addr_q <= wdata;
         else if (rld) addr_q <= rld_addr;
         else if (adv) addr_q <= addr_q + 1'b1;

         if (ld_word)  word_q <= wdata;
         else if (rld) word_q <= rld_word;
         else if (adv) word_q <= {word_q[AW-1:CW], word_q[CW-1:0] - 1'b1};
      end
   end
endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
   import dma_chreg_pkg::*;
#(
   parameter bit EXT_WRITE_EN = 1'b1
) (
   input  logic       go,
   input  xfer_type_e ty,
   input  logic       ext_mode,
   output strobe_t    stb,
   output logic       ext_write
);
   always_comb begin
      stb = '0;
      if (go) begin
         unique case (ty)
            XT_READ:  begin stb.mem_rd = 1'b1; stb.io_wr = 1'b1; end
            XT_WRITE: begin stb.io_rd  = 1'b1; stb.mem_wr = 1'b1; end
            default:  stb = '0;
         endcase
      end
   end

   if (EXT_WRITE_EN) begin : g_ext
      assign ext_write = ext_mode & (stb.mem_wr | stb.io_wr);
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_mode;
      assign ext_write  = 1'b0;
   end
endmodule

// File: rtl/dma_chreg_engine.sv
module dma_chreg_engine
   import dma_chreg_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int ADDR_W       = 16,
   parameter int CNT_W        = 14,
   parameter int RLD_DST      = 2,
   parameter int RLD_SRC      = 3,
   parameter bit EXT_WRITE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_wr,
   input  logic                    cpu_rd,
   input  logic [$clog2(2*NCH):0]  cpu_sel,
   input  logic [ADDR_W-1:0]       cpu_wdata,
   output logic [ADDR_W-1:0]       cpu_rdata,
   input  logic                    xfer_done,
   input  logic [$clog2(NCH)-1:0]  xfer_ch,
   output logic [NCH*ADDR_W-1:0]   ch_addr,
   output logic [NCH-1:0]          ch_tc,
   output logic                    mem_rd_en,
   output logic                    mem_wr_en,
   output logic                    io_rd_en,
   output logic                    io_wr_en,
   output logic                    ext_write
);
   localparam int TYPE_W  = 2;
   localparam int WORD_W  = CNT_W + TYPE_W;
   localparam int CH_W    = $clog2(NCH);
   localparam int SEL_W   = $clog2(2*NCH) + 1;
   localparam int MODE_W  = NCH + 4;
   localparam int STAT_W  = NCH + 1;
   localparam int MB_EXT  = NCH + 1;
   localparam int MB_STOP = NCH + 2;
   localparam int MB_AUTO = NCH + 3;
   localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(2*NCH);
   localparam logic [SEL_W-1:0] SEL_MODE = SEL_W'(2*NCH + 1);
   localparam logic [CH_W-1:0]  DST_CH   = CH_W'(RLD_DST);

   if (WORD_W != ADDR_W) begin : g_chk_w
      $error("dma_chreg_engine: count word must match address width");
   end
   if (RLD_DST >= NCH || RLD_SRC >= NCH || RLD_DST == RLD_SRC) begin : g_chk_r
      $error("dma_chreg_engine: bad reload channel pair");
   end
   if (MODE_W > ADDR_W) begin : g_chk_m
      $error("dma_chreg_engine: mode register wider than data bus");
   end

   logic [ADDR_W-1:0] addr_a [NCH];
   logic [WORD_W-1:0] word_a [NCH];
   logic [MODE_W-1:0] mode_q;
   logic [STAT_W-1:0] status_q;

   // selected-channel decode
   logic [WORD_W-1:0] xfer_word;
   xfer_type_e        xfer_ty;
   logic              go, tc_hit, reload;

   assign xfer_word = word_a[xfer_ch];
   assign xfer_ty   = xfer_type_e'(xfer_word[WORD_W-1 -: TYPE_W]);
   assign go        = xfer_done & mode_q[xfer_ch] & (xfer_ty != XT_BAD);
   assign tc_hit    = go & (xfer_word[CNT_W-1:0] == '0);
   assign reload    = tc_hit & mode_q[MB_AUTO] & (xfer_ch == DST_CH);

   // cpu write decode
   logic            chan_wr;
   logic [CH_W-1:0] wr_ch;
   assign chan_wr = cpu_wr & (cpu_sel < SEL_STAT);
   assign wr_ch   = cpu_sel[CH_W:1];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit_wr, hit_x;
      assign hit_wr = chan_wr & (wr_ch == CH_W'(i));
      assign hit_x  = xfer_ch == CH_W'(i);

      dma_ch_slot #(.AW(ADDR_W), .CW(CNT_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld_addr  (hit_wr & ~cpu_sel[0]),
         .ld_word  (hit_wr & cpu_sel[0]),
         .wdata    (cpu_wdata),
         .adv      (go & hit_x),
         .rld      ((i == RLD_DST) ? reload : 1'b0),
         .rld_addr (addr_a[RLD_SRC]),
         .rld_word (word_a[RLD_SRC]),
         .addr_q   (addr_a[i]),
         .word_q   (word_a[i])
      );

      assign ch_addr[i*ADDR_W +: ADDR_W] = addr_a[i];
      assign ch_tc[i] = tc_hit & hit_x;
   end

   // mode register: CPU write wins over the stop-at-terminal-count clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (cpu_wr && cpu_sel == SEL_STAT) begin
         mode_q <= cpu_wdata[MODE_W-1:0];
      end else if (tc_hit && mode_q[MB_STOP] && !reload) begin
         mode_q[xfer_ch] <= 1'b0;
      end
   end

   // status register: events in the read cycle survive the clear
   logic [STAT_W-1:0] stat_set;
   assign stat_set = {reload, ch_tc};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (cpu_rd && cpu_sel == SEL_STAT) begin
         status_q <= stat_set;
      end else begin
         status_q <= status_q | stat_set;
      end
   end

   always_comb begin
      cpu_rdata = '0;
      if (cpu_sel < SEL_STAT) begin
         cpu_rdata = cpu_sel[0] ? word_a[wr_ch] : addr_a[wr_ch];
      end else if (cpu_sel == SEL_STAT) begin
         cpu_rdata = ADDR_W'(status_q);
      end else if (cpu_sel == SEL_MODE) begin
         cpu_rdata = ADDR_W'(mode_q);
      end
   end

   strobe_t stb;
   dma_strobe_dec #(.EXT_WRITE_EN(EXT_WRITE_EN)) u_dec (
      .go        (go),
      .ty        (xfer_ty),
      .ext_mode  (mode_q[MB_EXT]),
      .stb       (stb),
      .ext_write (ext_write)
   );

   assign mem_rd_en = stb.mem_rd;
   assign mem_wr_en = stb.mem_wr;
   assign io_rd_en  = stb.io_rd;
   assign io_wr_en  = stb.io_wr;
endmodule

// File: rtl/dma_chreg_engine_chk.sv
module dma_chreg_engine_chk #(
   parameter int NCH   = 4,
   parameter int AW    = 16,
   parameter int SEL_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cpu_wr,
   input logic                 cpu_rd,
   input logic [SEL_W-1:0]     cpu_sel,
   input logic                 xfer_done,
   input logic [$clog2(NCH)-1:0] xfer_ch,
   input logic [AW-1:0]        xfer_word,
   input logic [NCH*AW-1:0]    ch_addr,
   input logic [NCH-1:0]       ch_tc,
   input logic                 mem_rd_en,
   input logic                 mem_wr_en,
   input logic                 io_rd_en,
   input logic                 io_wr_en,
   input logic                 ext_write,
   input logic [NCH+3:0]       mode_q,
   input logic [NCH:0]         status_q
);
   localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(2*NCH);
   logic [3:0] stb;
   assign stb = {mem_rd_en, mem_wr_en, io_rd_en, io_wr_en};

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && xfer_ch == '0 && mode_q[0] && xfer_word[AW-1 -: 2] != 2'b11 && !cpu_wr)
      |=> ch_addr[AW-1:0] == AW'($past(ch_addr[AW-1:0]) + 1'b1));

   assert_strobe_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(stb) == 0 || stb == 4'b1001 || stb == 4'b0110));

   assert_verify_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && xfer_word[AW-1 -: 2] == 2'b00) |-> stb == 4'b0000);

   assert_bad_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && xfer_word[AW-1 -: 2] == 2'b11) |-> (stb == 4'b0000 && ch_tc == '0));

   assert_tc_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_tc));

   assert_stop_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tc[0] && mode_q[NCH+2] && !cpu_wr) |=> !mode_q[0]);

   assert_update_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tc[2] && mode_q[NCH+3] && !cpu_wr) |=> status_q[NCH]);

   assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_sel == SEL_STAT && !xfer_done) |=> status_q == '0);

   assert_ext_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_write |-> ((mem_wr_en || io_wr_en) && mode_q[NCH+1]));
endmodule

bind dma_chreg_engine dma_chreg_engine_chk #(.NCH(NCH), .AW(ADDR_W), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_wr    (cpu_wr),
   .cpu_rd    (cpu_rd),
   .cpu_sel   (cpu_sel),
   .xfer_done (xfer_done),
   .xfer_ch   (xfer_ch),
   .xfer_word (xfer_word),
   .ch_addr   (ch_addr),
   .ch_tc     (ch_tc),
   .mem_rd_en (mem_rd_en),
   .mem_wr_en (mem_wr_en),
   .io_rd_en  (io_rd_en),
   .io_wr_en  (io_wr_en),
   .ext_write (ext_write),
   .mode_q    (mode_q),
   .status_q  (status_q)
);

// File: tb/dma_chreg_engine_tb.sv
`timescale 1ns/1ps
module dma_chreg_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [3:0]  cpu_sel = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        xfer_done = 1'b0;
   logic [1:0]  xfer_ch = '0;
   logic [63:0] ch_addr;
   logic [3:0]  ch_tc;
   logic        mem_rd_en, mem_wr_en, io_rd_en, io_wr_en, ext_write;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_chreg_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .xfer_done(xfer_done), .xfer_ch(xfer_ch), .ch_addr(ch_addr),
      .ch_tc(ch_tc), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
      .io_rd_en(io_rd_en), .io_wr_en(io_wr_en), .ext_write(ext_write)
   );

   // captured in the pulse cycle: {mem_rd, mem_wr, io_rd, io_wr}
   logic [3:0] cap_stb, cap_tc;
   logic       cap_ext;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_wr = 0; cpu_rd = 0; xfer_done = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] s, input logic [15:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] s, output logic [15:0] v);
      @(negedge clk);
      cpu_sel = s;
      #1 v = cpu_rdata;
   endtask

   task automatic rd_status(output logic [15:0] v);
      @(negedge clk);
      cpu_rd = 1'b1; cpu_sel = 4'd8;
      #1 v = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic xfer(input logic [1:0] ch);
      @(negedge clk);
      xfer_done = 1'b1; xfer_ch = ch;
      #1;
      cap_stb = {mem_rd_en, mem_wr_en, io_rd_en, io_wr_en};
      cap_tc  = ch_tc;
      cap_ext = ext_write;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      do_reset();
      for (int s = 0; s < 10; s++) begin
         rd(4'(s), v);
         chk($sformatf("R1 reset sel %0d", s), v, 16'h0000);
      end
      chk("R1 reset ch_addr", 16'(ch_addr != 0), 16'h0);
      chk("R1 reset outputs", {10'h0, ch_tc, mem_rd_en, ext_write}, 16'h0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      do_reset();
      wr(4'd2, 16'h1234); wr(4'd3, 16'h8005); wr(4'd8, 16'h001F);
      rd(4'd2, v); chk("R2 ch1 addr readback", v, 16'h1234);
      rd(4'd3, v); chk("R2 ch1 word readback", v, 16'h8005);
      rd(4'd9, v); chk("R2 mode readback", v, 16'h001F);
      chk("R2 ch_addr ch1", ch_addr[31:16], 16'h1234);
   endtask

   task automatic t_read_xfer();
      logic [15:0] v;
      do_reset();
      wr(4'd2, 16'h1234); wr(4'd3, 16'h8005); wr(4'd8, 16'h0002);
      xfer(2'd1);
      chk("R4 read strobes", {12'h0, cap_stb}, 16'h0009);
      chk("R6 no tc mid count", {12'h0, cap_tc}, 16'h0);
      chk("R3 addr step", ch_addr[31:16], 16'h1235);
      rd(4'd3, v); chk("R3 count step", v, 16'h8004);
   endtask

   task automatic t_write_xfer();
      logic [15:0] v;
      do_reset();
      wr(4'd0, 16'h0100); wr(4'd1, 16'h4002); wr(4'd8, 16'h0001);
      xfer(2'd0);
      chk("R4 write strobes", {12'h0, cap_stb}, 16'h0006);
      chk("R10 ext low without mode bit", {15'h0, cap_ext}, 16'h0);
      rd(4'd1, v); chk("R3 write count", v, 16'h4001);
   endtask

   task automatic t_verify();
      logic [15:0] v;
      do_reset();
      wr(4'd6, 16'hFFFF); wr(4'd7, 16'h0003); wr(4'd8, 16'h0008);
      xfer(2'd3);
      chk("R4 verify no strobes", {12'h0, cap_stb}, 16'h0);
      chk("R3 addr wraps", ch_addr[63:48], 16'h0000);
      rd(4'd7, v); chk("R4 verify count advances", v, 16'h0002);
   endtask

   task automatic t_ignored();
      logic [15:0] v;
      do_reset();
      wr(4'd4, 16'h2222); wr(4'd5, 16'hC001); wr(4'd8, 16'h0004);
      xfer(2'd2);
      chk("R5 illegal type strobes", {8'h0, cap_tc, cap_stb}, 16'h0);
      chk("R5 illegal addr kept", ch_addr[47:32], 16'h2222);
      rd(4'd5, v); chk("R5 illegal word kept", v, 16'hC001);
      wr(4'd0, 16'h0300); wr(4'd1, 16'h8000);
      xfer(2'd0);
      chk("R5 disabled strobes", {8'h0, cap_tc, cap_stb}, 16'h0);
      chk("R5 disabled addr kept", ch_addr[15:0], 16'h0300);
      rd(4'd8, v); chk("R5 disabled no status", v, 16'h0);
   endtask

   task automatic t_tc();
      logic [15:0] v;
      do_reset();
      wr(4'd2, 16'h0010); wr(4'd3, 16'h8000); wr(4'd8, 16'h0002);
      xfer(2'd1);
      chk("R6 tc pulse", {12'h0, cap_tc}, 16'h0002);
      rd(4'd3, v); chk("R6 count wraps", v, 16'hBFFF);
      rd(4'd9, v); chk("R7 stays enabled", v, 16'h0002);
      rd_status(v); chk("R9 status shows tc", v, 16'h0002);
      rd(4'd8, v);  chk("R9 status cleared", v, 16'h0000);
   endtask

   task automatic t_stop();
      logic [15:0] v;
      do_reset();
      wr(4'd3, 16'h8000); wr(4'd8, 16'h0042);
      xfer(2'd1);
      rd(4'd9, v); chk("R7 stop clears enable", v, 16'h0040);
      xfer(2'd1);
      chk("R7 stopped channel idle", {12'h0, cap_stb}, 16'h0);
   endtask

   task automatic t_autoload();
      logic [15:0] v;
      do_reset();
      wr(4'd6, 16'hA000); wr(4'd7, 16'h8010);
      wr(4'd4, 16'h2000); wr(4'd5, 16'h8000); wr(4'd8, 16'h00C4);
      xfer(2'd2);
      chk("R8 ch2 tc", {12'h0, cap_tc}, 16'h0004);
      chk("R8 ch2 addr reloaded", ch_addr[47:32], 16'hA000);
      rd(4'd5, v); chk("R8 ch2 word reloaded", v, 16'h8010);
      rd(4'd9, v); chk("R8 ch2 stays enabled", v, 16'h00C4);
      rd_status(v); chk("R8 update flag", v, 16'h0014);
   endtask

   task automatic t_ext();
      do_reset();
      wr(4'd3, 16'h8005); wr(4'd8, 16'h0022);
      xfer(2'd1); chk("R10 ext on read", {15'h0, cap_ext}, 16'h1);
      wr(4'd3, 16'h4005);
      xfer(2'd1); chk("R10 ext on write", {15'h0, cap_ext}, 16'h1);
      wr(4'd3, 16'h0005);
      xfer(2'd1); chk("R10 ext off verify", {15'h0, cap_ext}, 16'h0);
   endtask

   task automatic t_status_race();
      logic [15:0] v;
      do_reset();
      wr(4'd3, 16'h8000); wr(4'd1, 16'h8000); wr(4'd8, 16'h0003);
      xfer(2'd1);
      @(negedge clk);
      cpu_rd = 1'b1; cpu_sel = 4'd8; xfer_done = 1'b1; xfer_ch = 2'd0;
      #1 v = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0; xfer_done = 1'b0;
      chk("R9 read returns old status", v, 16'h0002);
      rd(4'd8, v); chk("R9 same-cycle event kept", v, 16'h0001);
   endtask

   task automatic t_cpu_wins();
      logic [15:0] v;
      do_reset();
      wr(4'd2, 16'h1000); wr(4'd3, 16'h8009); wr(4'd8, 16'h0002);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_sel = 4'd2; cpu_wdata = 16'h5555;
      xfer_done = 1'b1; xfer_ch = 2'd1;
      @(negedge clk);
      cpu_wr = 1'b0; xfer_done = 1'b0;
      chk("R11 cpu addr wins", ch_addr[31:16], 16'h5555);
      rd(4'd3, v); chk("R11 count still advances", v, 16'h8008);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_read_xfer();
      t_write_xfer();
      t_verify();
      t_ignored();
      t_tc();
      t_stop();
      t_autoload();
      t_ext();
      t_status_race();
      t_cpu_wins();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule